// File: doc/BRIEF.md
# Byte-Wide SPI Master with Collision and Mode-Fault Detection

This block is the master side of a synchronous serial link. The host loads a control word that holds the enable, master-select, clock polarity, clock phase, rate and interrupt-enable settings. It then writes a byte to start an exchange. During the exchange the block drives the serial clock. It shifts the byte out on the data-out line, most significant bit first, and captures a byte from the data-in line at the same time. When the last clock edge has passed, the received byte appears on `rx_data` and a completion flag rises.

Two error conditions are watched. The first is a host write that arrives while a byte is still moving. That write is dropped, the byte in flight is not disturbed, and a collision flag is raised. The second is the slave-select input being pulled low by another node while this block is an enabled master. In that case the block leaves master operation: its enable and master-select bits clear, any exchange in flight is abandoned, and the clock and data-out drivers switch off. A fault flag is also raised. An interrupt request combines completion and fault under one enable bit.

Top module: `spi_xfer_master`

## Requirements
- R1: A data write while the block is an enabled, idle master starts one exchange that sends the written byte most significant bit first and captures one byte from `spi_miso`. The captured byte is placed on `rx_data` in the cycle the exchange ends.
- R2: Outside an exchange `spi_sck` rests at the polarity bit. An exchange produces 16 clock edges spaced H system clocks apart, where H is 1, 2, 8 or 16 for rate codes 0, 1, 2 and 3. This gives SCK periods of 2, 4, 16 and 32 clocks.
- R3: With phase 0, the first data bit is on `spi_mosi` before the first edge, `spi_miso` is sampled on the odd edges, and `spi_mosi` changes on the even edges. With phase 1, `spi_mosi` changes on the odd edges and `spi_miso` is sampled on the even edges.
- R4: `busy` is high for exactly 16*H cycles, starting with the cycle after the write edge. `done_flag` rises at the edge that ends the exchange.
- R5: A data write while `busy` is high sets `wcol_flag` at the next edge. It changes neither the byte sent nor the byte received.
- R6: If `spi_ss_n` is low for two synchronizer stages while the block is an enabled master, `fault_flag` sets, `en_o` and `mstr_o` clear, and `busy` drops without setting `done_flag`. `rx_data` keeps its old value and `spi_drv_en` goes low.
- R7: `irq` is high exactly when the interrupt-enable bit is set and either `done_flag` or `fault_flag` is high.
- R8: A pulse on `clr_done`, `clr_wcol` or `clr_fault` clears the corresponding flag at the next edge.
- R9: A data write while the block is not an enabled master is ignored. No exchange starts and no flag changes.
- R10: A low `spi_ss_n` while the block is enabled but not master causes no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Load the control word |
| ctl_ie | input | 1 | Interrupt enable |
| ctl_en | input | 1 | System enable |
| ctl_mstr | input | 1 | Master select |
| ctl_cpol | input | 1 | Clock polarity (idle level) |
| ctl_cpha | input | 1 | Clock phase |
| ctl_rate | input | 2 | Rate code: SCK = clk divided by 2, 4, 16, 32 |
| dat_we | input | 1 | Data write strobe |
| dat_wdata | input | 8 | Byte to send |
| clr_done | input | 1 | Clear completion flag |
| clr_wcol | input | 1 | Clear collision flag |
| clr_fault | input | 1 | Clear fault flag |
| rx_data | output | 8 | Last received byte |
| busy | output | 1 | Exchange in progress |
| done_flag | output | 1 | Exchange completed |
| wcol_flag | output | 1 | Write collision seen |
| fault_flag | output | 1 | Mode fault seen |
| irq | output | 1 | Interrupt request |
| en_o | output | 1 | Current system enable bit |
| mstr_o | output | 1 | Current master-select bit |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_drv_en | output | 1 | Output enable for the clock and data-out pads |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | input | 1 | Slave-select input, watched for mode fault |

## Verification
The assertions check several relations on every cycle. A write during an exchange must raise the collision flag. A fault must leave the block with master and enable cleared, idle, and not driving. The interrupt request may only appear when a flag backs it. Every fall of `busy` must come with either completion or fault. The clock must rest at its polarity when idle, and writes to a disabled block must not start anything. Only the bench's scenarios show that the bits leave and arrive in the right order, with the right sampling edge, for every polarity, phase and rate. They also show that a collided write leaves both bytes intact and that an abandoned exchange keeps the previous received byte.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  typedef enum logic [1:0] {
    RATE_DIV2  = 2'd0,
    RATE_DIV4  = 2'd1,
    RATE_DIV16 = 2'd2,
    RATE_DIV32 = 2'd3
  } spi_rate_e;

  typedef struct packed {
    logic      ie;
    logic      en;
    logic      mstr;
    logic      cpol;
    logic      cpha;
    spi_rate_e rate;
  } spi_ctl_t;

endpackage

// File: rtl/spi_xfer_clkgen.sv
module spi_xfer_clkgen
  import spi_xfer_pkg::*;
#(
  parameter int DIV0 = 2,
  parameter int DIV1 = 4,
  parameter int DIV2 = 16,
  parameter int DIV3 = 32
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      start,
  input  spi_rate_e rate,
  output logic      tick
);

  localparam int HMAX = DIV3 / 2;
  localparam int HCW  = $clog2(HMAX) + 1;

  logic [HCW-1:0] half_m1;
  logic [HCW-1:0] hc_q, hc_d;

  always_comb begin
    unique case (rate)
      RATE_DIV2:  half_m1 = HCW'(DIV0 / 2 - 1);
      RATE_DIV4:  half_m1 = HCW'(DIV1 / 2 - 1);
      RATE_DIV16: half_m1 = HCW'(DIV2 / 2 - 1);
      default:    half_m1 = HCW'(DIV3 / 2 - 1);
    endcase
  end

  assign tick = run && (hc_q == half_m1);

  always_comb begin
    if (!run || start || tick) hc_d = '0;
    else                       hc_d = hc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hc_q <= '0;
    else        hc_q <= hc_d;
  end

endmodule

// File: rtl/spi_xfer_shifter.sv
module spi_xfer_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cpha,
  input  logic              shift_en,
  input  logic              odd_edge,
  input  logic              load_rx,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_data
);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic              lat_q, lat_d;
  logic              mosi_q, mosi_d;

  always_comb begin
    sh_d   = sh_q;
    lat_d  = lat_q;
    mosi_d = mosi_q;
    rx_d   = rx_q;
    if (start) begin
      sh_d = wdata;
      if (!cpha) mosi_d = wdata[DATA_W-1];
    end else if (shift_en) begin
      if (odd_edge) begin
        if (cpha) mosi_d = sh_q[DATA_W-1];
        else      lat_d  = miso;
      end else begin
        sh_d = cpha ? {sh_q[DATA_W-2:0], miso} : {sh_q[DATA_W-2:0], lat_q};
        if (!cpha) mosi_d = sh_q[DATA_W-2];
      end
    end
    if (load_rx) rx_d = sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      lat_q  <= 1'b0;
      mosi_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      sh_q   <= sh_d;
      lat_q  <= lat_d;
      mosi_q <= mosi_d;
      rx_q   <= rx_d;
    end
  end

  assign mosi    = mosi_q;
  assign rx_data = rx_q;

endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ctl_we,
  input  spi_ctl_t ctl_wdata,
  input  logic     dat_we,
  input  logic     clr_done,
  input  logic     clr_wcol,
  input  logic     clr_fault,
  input  logic     ss_n,
  input  logic     tick,
  output spi_ctl_t ctl,
  output logic     start,
  output logic     busy,
  output logic     shift_en,
  output logic     odd_edge,
  output logic     load_rx,
  output logic     sck,
  output logic     done_flag,
  output logic     wcol_flag,
  output logic     fault_flag
);

  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);

  spi_ctl_t       ctl_q, ctl_d;
  logic           busy_q, busy_d;
  logic [EW-1:0]  ecnt_q, ecnt_d;
  logic           sck_q, sck_d;
  logic           done_q, done_d;
  logic           wcol_q, wcol_d;
  logic           fault_q, fault_d;
  logic [SYNC_STAGES-1:0] ss_sync_q;
  logic           fault_cond, last_edge;

  // slave-select synchronizer chain
  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ss_sync_q[g] <= 1'b1;
        else if (g == 0) ss_sync_q[g] <= ss_n;
        else ss_sync_q[g] <= ss_sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign fault_cond = ctl_q.en && ctl_q.mstr && !ss_sync_q[SYNC_STAGES-1];
  assign start      = dat_we && ctl_q.en && ctl_q.mstr && !busy_q && !fault_cond;
  assign last_edge  = tick && (ecnt_q == EW'(EDGES - 1));
  assign odd_edge   = !ecnt_q[0];
  assign shift_en   = tick && !fault_cond;
  assign load_rx    = last_edge && !fault_cond;

  always_comb begin
    ctl_d = ctl_we ? ctl_wdata : ctl_q;
    if (fault_cond) begin
      ctl_d.en   = 1'b0;
      ctl_d.mstr = 1'b0;
    end

    busy_d = busy_q;
    if (fault_cond)     busy_d = 1'b0;
    else if (start)     busy_d = 1'b1;
    else if (last_edge) busy_d = 1'b0;

    ecnt_d = ecnt_q;
    if (start)     ecnt_d = '0;
    else if (tick) ecnt_d = ecnt_q + 1'b1;

    if (fault_cond || !busy_q) sck_d = ctl_q.cpol;
    else if (tick)             sck_d = !sck_q;
    else                       sck_d = sck_q;

    done_d = done_q;
    if (load_rx)       done_d = 1'b1;
    else if (clr_done) done_d = 1'b0;

    wcol_d = wcol_q;
    if (dat_we && busy_q) wcol_d = 1'b1;
    else if (clr_wcol)    wcol_d = 1'b0;

    fault_d = fault_q;
    if (fault_cond)     fault_d = 1'b1;
    else if (clr_fault) fault_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      busy_q  <= 1'b0;
      ecnt_q  <= '0;
      sck_q   <= 1'b0;
      done_q  <= 1'b0;
      wcol_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      busy_q  <= busy_d;
      ecnt_q  <= ecnt_d;
      sck_q   <= sck_d;
      done_q  <= done_d;
      wcol_q  <= wcol_d;
      fault_q <= fault_d;
    end
  end

  assign ctl        = ctl_q;
  assign busy       = busy_q;
  assign sck        = sck_q;
  assign done_flag  = done_q;
  assign wcol_flag  = wcol_q;
  assign fault_flag = fault_q;

endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIV0        = 2,
  parameter int DIV1        = 4,
  parameter int DIV2        = 16,
  parameter int DIV3        = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic              ctl_ie,
  input  logic              ctl_en,
  input  logic              ctl_mstr,
  input  logic              ctl_cpol,
  input  logic              ctl_cpha,
  input  logic [1:0]        ctl_rate,
  input  logic              dat_we,
  input  logic [DATA_W-1:0] dat_wdata,
  input  logic              clr_done,
  input  logic              clr_wcol,
  input  logic              clr_fault,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              done_flag,
  output logic              wcol_flag,
  output logic              fault_flag,
  output logic              irq,
  output logic              en_o,
  output logic              mstr_o,
  output logic              spi_sck,
  output logic              spi_mosi,
  output logic              spi_drv_en,
  input  logic              spi_miso,
  input  logic              spi_ss_n
);

  spi_ctl_t ctl_wdata, ctl_cur;
  logic     start, tick, shift_en, odd_edge, load_rx;

  assign ctl_wdata = '{ie: ctl_ie, en: ctl_en, mstr: ctl_mstr, cpol: ctl_cpol,
                       cpha: ctl_cpha, rate: spi_rate_e'(ctl_rate)};

  spi_xfer_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .dat_we(dat_we), .clr_done(clr_done), .clr_wcol(clr_wcol),
    .clr_fault(clr_fault), .ss_n(spi_ss_n), .tick(tick), .ctl(ctl_cur),
    .start(start), .busy(busy), .shift_en(shift_en), .odd_edge(odd_edge),
    .load_rx(load_rx), .sck(spi_sck), .done_flag(done_flag),
    .wcol_flag(wcol_flag), .fault_flag(fault_flag)
  );

  spi_xfer_clkgen #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(busy), .start(start),
    .rate(ctl_cur.rate), .tick(tick)
  );

  spi_xfer_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .wdata(dat_wdata),
    .cpha(ctl_cur.cpha), .shift_en(shift_en), .odd_edge(odd_edge),
    .load_rx(load_rx), .miso(spi_miso), .mosi(spi_mosi), .rx_data(rx_data)
  );

  assign en_o       = ctl_cur.en;
  assign mstr_o     = ctl_cur.mstr;
  assign spi_drv_en = ctl_cur.en && ctl_cur.mstr;
  assign irq        = ctl_cur.ie && (done_flag || fault_flag);

endmodule

// File: rtl/spi_xfer_sva.sv
module spi_xfer_sva (
  input logic clk,
  input logic rst_n,
  input logic dat_we,
  input logic busy,
  input logic done_flag,
  input logic wcol_flag,
  input logic fault_flag,
  input logic irq,
  input logic en_o,
  input logic mstr_o,
  input logic spi_drv_en,
  input logic spi_sck,
  input logic cpol
);

  a_r5_wcol_on_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    busy && dat_we |=> wcol_flag);

  a_r6_fault_leaves_master: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_flag) |-> !en_o && !mstr_o && !busy);

  a_r6_fault_releases_pads: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_flag) |-> !spi_drv_en);

  a_r7_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_flag || fault_flag);

  a_r4_end_is_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag || fault_flag);

  a_r2_sck_rests_at_cpol: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && cpol == $past(cpol)) |-> spi_sck == cpol);

  a_r9_disabled_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    dat_we && !en_o |=> !busy);

endmodule

bind spi_xfer_master spi_xfer_sva u_sva (
  .clk(clk), .rst_n(rst_n), .dat_we(dat_we), .busy(busy),
  .done_flag(done_flag), .wcol_flag(wcol_flag), .fault_flag(fault_flag),
  .irq(irq), .en_o(en_o), .mstr_o(mstr_o), .spi_drv_en(spi_drv_en),
  .spi_sck(spi_sck), .cpol(ctl_cur.cpol)
);

// File: tb/tb_spi_xfer_master.sv
module tb_spi_xfer_master;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 0, ctl_ie = 0, ctl_en = 0, ctl_mstr = 0, ctl_cpol = 0, ctl_cpha = 0;
  logic [1:0] ctl_rate = 0;
  logic       dat_we = 0;
  logic [7:0] dat_wdata = 0;
  logic       clr_done = 0, clr_wcol = 0, clr_fault = 0;
  logic [7:0] rx_data;
  logic       busy, done_flag, wcol_flag, fault_flag, irq, en_o, mstr_o;
  logic       spi_sck, spi_mosi, spi_drv_en;
  logic       spi_miso = 0, spi_ss_n = 1;

  always #10 clk = ~clk;

  spi_xfer_master dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_ie(ctl_ie), .ctl_en(ctl_en),
    .ctl_mstr(ctl_mstr), .ctl_cpol(ctl_cpol), .ctl_cpha(ctl_cpha),
    .ctl_rate(ctl_rate), .dat_we(dat_we), .dat_wdata(dat_wdata),
    .clr_done(clr_done), .clr_wcol(clr_wcol), .clr_fault(clr_fault),
    .rx_data(rx_data), .busy(busy), .done_flag(done_flag),
    .wcol_flag(wcol_flag), .fault_flag(fault_flag), .irq(irq), .en_o(en_o),
    .mstr_o(mstr_o), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_drv_en(spi_drv_en), .spi_miso(spi_miso), .spi_ss_n(spi_ss_n)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_en, m_mstr, m_cpol, m_cpha, m_ie, m_busy, m_done, m_wcol, m_fault, m_sck;
  int m_rate, m_cyc;
  bit ss1, ss2;

  function automatic int half_of(input int r);
    case (r)
      0: return 1;
      1: return 2;
      2: return 8;
      default: return 16;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_en, m_mstr, m_cpol, m_cpha, m_ie} = '0;
      {m_busy, m_done, m_wcol, m_fault, m_sck} = '0;
      m_rate = 0; m_cyc = 0; ss1 = 1; ss2 = 1;
    end else begin
      bit fc, st, lst, nbusy;
      int h, ncyc;
      h   = half_of(m_rate);
      fc  = m_en && m_mstr && !ss2;
      st  = dat_we && m_en && m_mstr && !m_busy && !fc;
      lst = m_busy && (m_cyc == 16 * h - 1);
      if (dat_we && m_busy) m_wcol = 1; else if (clr_wcol) m_wcol = 0;
      if (lst && !fc) m_done = 1; else if (clr_done) m_done = 0;
      if (fc) m_fault = 1; else if (clr_fault) m_fault = 0;
      nbusy = fc ? 0 : st ? 1 : lst ? 0 : m_busy;
      ncyc  = st ? 0 : (m_busy ? m_cyc + 1 : m_cyc);
      m_sck = nbusy ? (m_cpol ^ ((ncyc / h) % 2 == 1)) : m_cpol;
      m_busy = nbusy;
      m_cyc  = ncyc;
      if (ctl_we) begin
        m_en = ctl_en; m_mstr = ctl_mstr; m_cpol = ctl_cpol;
        m_cpha = ctl_cpha; m_rate = ctl_rate; m_ie = ctl_ie;
      end
      if (fc) begin m_en = 0; m_mstr = 0; end
      ss2 = ss1; ss1 = spi_ss_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(busy == m_busy, "R4 busy", busy, m_busy);
      chk(spi_sck == m_sck, "R2 sck", spi_sck, m_sck);
      chk(done_flag == m_done, "R4 done", done_flag, m_done);
      chk(wcol_flag == m_wcol, "R5 wcol", wcol_flag, m_wcol);
      chk(fault_flag == m_fault, "R6 fault", fault_flag, m_fault);
      chk(en_o == m_en && mstr_o == m_mstr, "R6 en/mstr", {en_o, mstr_o}, {m_en, m_mstr});
      chk(spi_drv_en == (m_en && m_mstr), "R6 drv", spi_drv_en, m_en && m_mstr);
      chk(irq == (m_ie && (m_done || m_fault)), "R7 irq", irq, m_ie && (m_done || m_fault));
    end
  end

  // ---------------- slave model ----------------
  bit       s_act = 0, cur_cpol = 0, cur_cpha = 0;
  logic [7:0] s_out, s_rx;

  always @(spi_sck) begin
    if (s_act) begin
      bit leading;
      leading = (spi_sck != cur_cpol);
      if (leading != cur_cpha) s_rx = {s_rx[6:0], spi_mosi};
      else begin
        if (cur_cpha) begin spi_miso = s_out[7]; s_out = s_out << 1; end
        else          begin spi_miso = s_out[7]; s_out = s_out << 1; end
      end
    end
  end

  task automatic cfg(input bit en, input bit m, input bit pol, input bit pha,
                     input int r, input bit ie);
    @(negedge clk);
    ctl_we = 1; ctl_en = en; ctl_mstr = m; ctl_cpol = pol; ctl_cpha = pha;
    ctl_rate = 2'(r); ctl_ie = ie;
    @(negedge clk);
    ctl_we = 0; cur_cpol = pol; cur_cpha = pha;
    @(negedge clk);
  endtask

  task automatic begin_xfer(input logic [7:0] m, input logic [7:0] s);
    s_rx = 0;
    s_out = s;
    if (!cur_cpha) begin spi_miso = s[7]; s_out = s << 1; end
    s_act = 1;
    @(negedge clk);
    dat_we = 1; dat_wdata = m;
    @(negedge clk);
    dat_we = 0;
  endtask

  task automatic xfer(input logic [7:0] m, input logic [7:0] s, input int coll_at,
                      input string tag);
    begin_xfer(m, s);
    if (coll_at > 0) begin
      repeat (coll_at) @(negedge clk);
      dat_we = 1; dat_wdata = ~m;
      @(negedge clk);
      dat_we = 0;
    end
    while (busy) @(negedge clk);
    s_act = 0;
    chk(rx_data == s, {tag, " rx byte"}, rx_data, s);
    chk(s_rx == m, {tag, " tx byte"}, s_rx, m);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_done = 1; clr_wcol = 1; clr_fault = 1;
    @(negedge clk); clr_done = 0; clr_wcol = 0; clr_fault = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] keep;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state (R4, R6)
    chk(!busy && !done_flag && !wcol_flag && !fault_flag, "R4 reset flags",
        {busy, done_flag, wcol_flag, fault_flag}, 0);
    chk(!spi_drv_en && !en_o && rx_data == 0, "R6 reset drive", spi_drv_en, 0);

    // R9: write to a disabled block
    @(negedge clk); dat_we = 1; dat_wdata = 8'h3C;
    @(negedge clk); dat_we = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !wcol_flag, "R9 ignored write", {busy, wcol_flag}, 0);

    // R1 R2 R3: all polarity, phase and rate combinations
    for (int k = 0; k < 16; k++) begin
      logic [7:0] mb, sb;
      mb = 8'hA5 ^ 8'(k * 37);
      sb = 8'h5A ^ 8'(k * 91 + 3);
      cfg(1, 1, k[0], k[1], k >> 2, 0);
      xfer(mb, sb, 0, "R1 R3");
      chk(done_flag == 1, "R4 done after exchange", done_flag, 1);
    end
    xfer(8'h80, 8'h01, 0, "R1 edge bits");
    xfer(8'hFF, 8'h00, 0, "R3 all ones");

    // R8 clear
    pulse_clr();
    chk(!done_flag, "R8 done cleared", done_flag, 0);

    // R5: collision
    cfg(1, 1, 0, 0, 1, 0);
    xfer(8'hC3, 8'h96, 5, "R5 collide");
    chk(wcol_flag == 1, "R5 wcol set", wcol_flag, 1);
    cfg(1, 1, 1, 1, 2, 0);
    xfer(8'h1E, 8'hE1, 40, "R5 collide pha1");
    pulse_clr();
    chk(!wcol_flag && !done_flag, "R8 wcol cleared", {wcol_flag, done_flag}, 0);

    // R7 irq on done
    cfg(1, 1, 0, 1, 0, 1);
    xfer(8'h69, 8'h96, 0, "R7 xfer");
    chk(irq == 1, "R7 irq on done", irq, 1);
    pulse_clr();
    chk(irq == 0, "R7 irq cleared", irq, 0);

    // R10: slave-select low while not master
    cfg(1, 0, 0, 0, 0, 1);
    @(negedge clk); spi_ss_n = 0;
    repeat (6) @(negedge clk);
    chk(!fault_flag, "R10 no fault when not master", fault_flag, 0);
    spi_ss_n = 1;
    repeat (4) @(negedge clk);

    // R6: mode fault during an exchange
    cfg(1, 1, 0, 0, 3, 1);
    keep = rx_data;
    begin_xfer(8'hAA, 8'h55);
    repeat (30) @(negedge clk);
    spi_ss_n = 0;
    repeat (5) @(negedge clk);
    s_act = 0;
    chk(fault_flag == 1, "R6 fault set", fault_flag, 1);
    chk(!en_o && !mstr_o && !busy, "R6 master left", {en_o, mstr_o, busy}, 0);
    chk(!spi_drv_en, "R6 pads released", spi_drv_en, 0);
    chk(!done_flag, "R6 no done", done_flag, 0);
    chk(rx_data == keep, "R6 rx kept", rx_data, keep);
    chk(irq == 1, "R7 irq on fault", irq, 1);
    // R9: write after fault left master
    @(negedge clk); dat_we = 1; dat_wdata = 8'h11;
    @(negedge clk); dat_we = 0;
    repeat (2) @(negedge clk);
    chk(!busy, "R9 write after fault", busy, 0);
    spi_ss_n = 1;
    pulse_clr();
    chk(!fault_flag, "R8 fault cleared", fault_flag, 0);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule